// File: doc/BRIEF.md
# Alternate Bus Master Seizure Controller

This block lets a plug-in card become master of a system bus that normally belongs to a resident 68000-family processor. It uses the two-wire arbitration handshake. When local logic asks for the bus, the block pulls the active-low request line down. It then declares ownership once the processor can no longer be mid-cycle.

Ownership can be declared in one of two ways. The first is a fixed settling wait followed by an idle address strobe. The second, when the active-low grant line is seen asserted, is to take the bus as soon as the strobe is idle, with no fixed wait. On ownership the block first enables the card's address, data and control drivers, and raises the ownership flag to local logic one clock later. The bus is kept by holding the request line low for as long as the card needs it; no acknowledge line is driven.

Startup is handled as well. While reset is applied, and for a programmable number of clocks after it is released, the request line stays high and the card's control pins are forced to their inactive (high) level rather than floated. Requests are not honoured until that settling period has run. Release is staged: the drivers switch off first, and the request line returns high one clock later. Every signal arriving from the processor's bus passes through a synchronizer of SYNC_STAGES flip-flops (default 2) before any decision uses it.

Top module: `altm_bus_seize`

## Requirements
- R1: While rst_n_i is low, br_n_o is 1, drv_en_o is 0, owned_o is 0 and ctl_idle_o is 1, and a reset applied during ownership forces these values at once.
- R2: After reset release, br_n_o stays 1 for BOOT_CLKS (default 8) rising edges even with want_i held high.
- R3: Once the settling period has run and the block is idle, a high want_i drives br_n_o to 0 at the next rising edge.
- R4: Without an observed grant, drv_en_o rises no earlier than WAIT_CLKS+1 (default 3) rising edges after br_n_o falls.
- R5: Bus inputs are used only after SYNC_STAGES (default 2) flip-flops. Ownership is never declared while the synchronized strobe as_n_i is low. A strobe rise on as_n_i completes a pending acquisition three edges later.
- R6: With USE_GRANT=1 and bg_n_i synchronized low, ownership skips the settling wait. drv_en_o rises at the edge after br_n_o falls, provided the strobe is idle.
- R7: owned_o rises exactly one edge after drv_en_o rises, and ctl_idle_o is always the inverse of drv_en_o.
- R8: When want_i drops during ownership, drv_en_o and owned_o fall at the next edge, and br_n_o returns to 1 one edge after that.
- R9: br_n_o stays 0 for the entire time drv_en_o is 1.
- R10: If want_i drops while a request is pending, br_n_o returns to 1 at the next edge and ownership is not declared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Card clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| want_i | input | 1 | Local logic needs the bus while high |
| as_n_i | input | 1 | Processor address strobe, active low, asynchronous |
| bg_n_i | input | 1 | Processor bus grant, active low, asynchronous |
| br_n_o | output | 1 | Bus request to the processor, active low |
| drv_en_o | output | 1 | Enable for the card's address, data and control drivers |
| owned_o | output | 1 | Tells local logic it may start bus cycles |
| ctl_idle_o | output | 1 | Forces the card's control pins to their inactive high level |

## Verification
The bench drives inputs on falling edges and samples on falling edges, counting rising edges from each stimulus. br_n_o answers want_i one edge later. Plain acquisition completes three edges after br_n_o falls, and an acquisition through the grant completes one edge after it. A strobe change reaches a decision three edges after the pin moves, because of the two synchronizer stages. owned_o trails drv_en_o by one edge, and on release br_n_o rises two edges after want_i drops. Each scenario checks the exact edge of each change and the cycles just before it, so a change that comes one edge early or one edge late is reported.

// File: rtl/altm_pkg.sv
package altm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_HOLD = 2'd2,
        ST_DROP = 2'd3
    } seize_st_e;

endpackage

// File: rtl/altm_sync.sv
module altm_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stg_d;
        if (s == 0) begin : g_first
            always_comb stg_d = d_i;
        end else begin : g_next
            always_comb stg_d = stg_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) stg_q[s] <= {W{RST_VAL}};
            else          stg_q[s] <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/altm_boot_delay.sv
module altm_boot_delay #(
    parameter int CLKS = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic ready_o
);

    localparam int CW = $clog2(CLKS + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } boot_t;

    boot_t d, q;

    always_comb begin
        d = q;
        if (!q.ready) begin
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(CLKS - 1)) d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) q <= '0;
        else          q <= d;
    end

    assign ready_o = q.ready;

    AST_READY_AFTER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(q.ready) |-> (q.cnt == CW'(CLKS))); // R2

endmodule

// File: rtl/altm_seize_fsm.sv
module altm_seize_fsm
    import altm_pkg::*;
#(
    parameter int WAIT_CLKS = 2,
    parameter bit USE_GRANT = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ready_i,
    input  logic want_i,
    input  logic as_idle_i,
    input  logic bg_low_i,
    output logic br_n_o,
    output logic drv_en_o,
    output logic owned_o
);

    localparam int WW = $clog2(WAIT_CLKS + 2);

    typedef struct packed {
        seize_st_e     st;
        logic [WW-1:0] wcnt;
        logic          br_n;
        logic          drv_en;
        logic          owned;
    } seize_t;

    seize_t d, q;
    logic   grant_hit;
    logic   wait_done;

    if (USE_GRANT) begin : g_grant
        assign grant_hit = bg_low_i;
    end else begin : g_nogrant
        assign grant_hit = 1'b0;
    end

    assign wait_done = (q.wcnt == WW'(WAIT_CLKS));

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                d.wcnt = '0;
                if (ready_i && want_i) begin
                    d.st   = ST_ASK;
                    d.br_n = 1'b0;
                end
            end
            ST_ASK: begin
                if (!want_i) begin
                    d.st   = ST_IDLE;
                    d.br_n = 1'b1;
                end else begin
                    if (!wait_done) d.wcnt = q.wcnt + WW'(1);
                    if ((wait_done || grant_hit) && as_idle_i) begin
                        d.st     = ST_HOLD;
                        d.drv_en = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!want_i) begin
                    d.st     = ST_DROP;
                    d.drv_en = 1'b0;
                    d.owned  = 1'b0;
                end else begin
                    d.owned = 1'b1;
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.br_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.br_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign br_n_o   = q.br_n;
    assign drv_en_o = q.drv_en;
    assign owned_o  = q.owned;

    AST_NO_EARLY_TAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(q.drv_en) |-> $past(wait_done || grant_hit)); // R4

    AST_ABORT_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (q.st == ST_ASK && !want_i) |=> (q.br_n && !q.drv_en)); // R10

    AST_STAGED_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (q.drv_en && !want_i) |=> (!q.drv_en && !q.owned && !q.br_n) ##1 q.br_n); // R8

endmodule

// File: rtl/altm_bus_seize.sv
module altm_bus_seize #(
    parameter int SYNC_STAGES = 2,
    parameter int BOOT_CLKS   = 8,
    parameter int WAIT_CLKS   = 2,
    parameter bit USE_GRANT   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic want_i,
    input  logic as_n_i,
    input  logic bg_n_i,
    output logic br_n_o,
    output logic drv_en_o,
    output logic owned_o,
    output logic ctl_idle_o
);

    logic [1:0] bus_s;
    logic       ready;
    logic       as_idle;
    logic       bg_low;

    altm_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     ({as_n_i, bg_n_i}),
        .q_o     (bus_s)
    );

    assign as_idle = bus_s[1];
    assign bg_low  = !bus_s[0];

    altm_boot_delay #(
        .CLKS (BOOT_CLKS)
    ) boot_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .ready_o (ready)
    );

    altm_seize_fsm #(
        .WAIT_CLKS (WAIT_CLKS),
        .USE_GRANT (USE_GRANT)
    ) fsm_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .ready_i   (ready),
        .want_i    (want_i),
        .as_idle_i (as_idle),
        .bg_low_i  (bg_low),
        .br_n_o    (br_n_o),
        .drv_en_o  (drv_en_o),
        .owned_o   (owned_o)
    );

    assign ctl_idle_o = !drv_en_o;

    AST_QUIET_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !ready |-> (br_n_o && !drv_en_o)); // R2

    AST_TAKE_ON_IDLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(drv_en_o) |-> $past(as_idle)); // R5

    AST_HOLD_KEEPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        drv_en_o |-> !br_n_o); // R9

    AST_OWNED_AFTER_DRV: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(owned_o) |-> $past(drv_en_o)); // R7

    AST_REQ_DROP_AFTER_DRV: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(br_n_o) |-> (!drv_en_o && $past(!drv_en_o))); // R8

endmodule

// File: tb/altm_bus_seize_tb.sv
`timescale 1ns/1ps
module altm_bus_seize_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic want;
    logic as_n;
    logic bg_n;
    logic br_n;
    logic drv_en;
    logic owned;
    logic ctl_idle;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    altm_bus_seize dut_i (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .want_i     (want),
        .as_n_i     (as_n),
        .bg_n_i     (bg_n),
        .br_n_o     (br_n),
        .drv_en_o   (drv_en),
        .owned_o    (owned),
        .ctl_idle_o (ctl_idle)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boot();
        rst_n = 1'b0;
        want  = 1'b0;
        as_n  = 1'b1;
        bg_n  = 1'b1;
        nclk(3);
        rst_n = 1'b1;
        nclk(10);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; want = 1'b0; as_n = 1'b1; bg_n = 1'b1;
        nclk(2);
        chk("R1", "br_n in reset", br_n, 1'b1);
        chk("R1", "drv_en in reset", drv_en, 1'b0);
        chk("R1", "owned in reset", owned, 1'b0);
        chk("R1", "ctl_idle in reset", ctl_idle, 1'b1);
        rst_n = 1'b1;
        nclk(10);
        want = 1'b1;
        nclk(6);
        chk("R1", "owned before mid reset", owned, 1'b1);
        rst_n = 1'b0;
        #1;
        chk("R1", "br_n after mid reset", br_n, 1'b1);
        chk("R1", "drv_en after mid reset", drv_en, 1'b0);
        chk("R1", "ctl_idle after mid reset", ctl_idle, 1'b1);
        want = 1'b0;
        nclk(2);
    endtask

    task automatic t_boot_hold();
        rst_n = 1'b0; want = 1'b1; as_n = 1'b1; bg_n = 1'b1;
        nclk(3);
        rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            nclk(1);
            chk("R2", $sformatf("br_n at edge %0d", k), br_n, 1'b1);
        end
        nclk(1);
        chk("R3", "br_n after settling", br_n, 1'b0);
        want = 1'b0;
        nclk(4);
    endtask

    task automatic t_plain_acquire();
        boot();
        want = 1'b1;
        nclk(1);
        chk("R3", "br_n one edge after want", br_n, 1'b0);
        chk("R4", "drv_en edge 1", drv_en, 1'b0);
        nclk(1);
        chk("R4", "drv_en edge 2", drv_en, 1'b0);
        nclk(1);
        chk("R4", "drv_en edge 3", drv_en, 1'b0);
        nclk(1);
        chk("R4", "drv_en edge 4", drv_en, 1'b1);
        chk("R7", "owned lags drv_en", owned, 1'b0);
        chk("R7", "ctl_idle when driving", ctl_idle, 1'b0);
        nclk(1);
        chk("R7", "owned one edge later", owned, 1'b1);
        nclk(5);
        chk("R9", "br_n held during ownership", br_n, 1'b0);
        chk("R9", "drv_en held", drv_en, 1'b1);
        want = 1'b0;
        nclk(1);
        chk("R8", "drv_en off first", drv_en, 1'b0);
        chk("R8", "owned off first", owned, 1'b0);
        chk("R8", "br_n still low", br_n, 1'b0);
        chk("R7", "ctl_idle after release", ctl_idle, 1'b1);
        nclk(1);
        chk("R8", "br_n high one edge later", br_n, 1'b1);
        nclk(3);
    endtask

    task automatic t_strobe_busy();
        boot();
        as_n = 1'b0;
        nclk(3);
        want = 1'b1;
        nclk(6);
        chk("R5", "br_n low while strobe busy", br_n, 1'b0);
        chk("R5", "no take while strobe busy", drv_en, 1'b0);
        as_n = 1'b1;
        nclk(1);
        chk("R5", "strobe stage 1", drv_en, 1'b0);
        nclk(1);
        chk("R5", "strobe stage 2", drv_en, 1'b0);
        nclk(1);
        chk("R5", "take after synced strobe", drv_en, 1'b1);
        want = 1'b0;
        nclk(4);
    endtask

    task automatic t_grant_fast();
        boot();
        bg_n = 1'b0;
        nclk(3);
        want = 1'b1;
        nclk(1);
        chk("R6", "br_n low", br_n, 1'b0);
        chk("R6", "no drv yet", drv_en, 1'b0);
        nclk(1);
        chk("R6", "grant skips wait", drv_en, 1'b1);
        want = 1'b0;
        nclk(3);
        bg_n = 1'b1;
        nclk(3);
    endtask

    task automatic t_abort();
        boot();
        want = 1'b1;
        nclk(1);
        chk("R10", "br_n low before abort", br_n, 1'b0);
        want = 1'b0;
        nclk(1);
        chk("R10", "br_n high after abort", br_n, 1'b1);
        chk("R10", "no drv after abort", drv_en, 1'b0);
        nclk(3);
        chk("R10", "still no drv", drv_en, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; want = 1'b0; as_n = 1'b1; bg_n = 1'b1;
        t_reset_state();
        t_boot_hold();
        t_plain_acquire();
        t_strobe_busy();
        t_grant_fast();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

endmodule